// File: doc/BRIEF.md
# Composite Sync Separator with Phase-Detector Inhibit

This block sits on a fast sampling clock behind the sync input comparator of a horizontal timebase. The sync input may be a plain horizontal sync or a composite sync, and its active level is not known in advance. The block first settles the input's active level. It then delivers a normalized active-high sync with a one-cycle marker on each leading edge, and it measures the line period as the spacing between those edges.

Every normalized pulse is timed while it is high. The running width is compared with a threshold of about 30% of the measured line period. A pulse that outlasts the threshold is passed on as extracted vertical sync. This happens well inside half a line, so missing serration pulses have no time to disturb the line oscillator.

Extracted vertical sync also opens an inhibit window for the horizontal phase detector. The window is controlled by a three-state machine with states INH_IDLE, INH_VERT and INH_TRAIL:
- INH_IDLE goes to INH_VERT when vertical sync appears.
- INH_VERT goes to INH_TRAIL when vertical sync ends.
- INH_TRAIL goes back to INH_VERT if vertical sync returns, for example after a serration gap.
- INH_TRAIL goes to INH_IDLE on the last of a fixed number of line ticks from the timebase.

The line-period measurement is frozen while the window is open. A disable input masks the inhibit output without affecting extraction.

Top module: `composite_sync_sep`

## Requirements
- R1: After reset, sync_norm, sync_lead, vsync_out, pd_inhibit, pol_neg and composite are 0, and line_period is 0.
- R2: An INTEG_W-bit saturating integrator counts up on each high input sample and down on each low one. pol_neg (1 = active-low input) follows whether the integrator is at or above half scale. Once the level is settled, sync_norm is the input made active-high, with each pulse's width preserved. sync_lead gives exactly one cycle per pulse.
- R3: Starting from a saturated integrator, an excursion to the opposite level lasting fewer than 2^(INTEG_W-1) samples leaves pol_neg unchanged.
- R4: line_period is the number of sample clocks between two consecutive sync_lead pulses. It is updated at each leading edge that falls outside the inhibit window.
- R5: The threshold is floor(line_period*77/256). A normalized pulse of W samples with W greater than the threshold drives vsync_out high for exactly W minus the threshold cycles. Shorter pulses leave vsync_out low.
- R6: vsync_out rises threshold+1 cycles after the sync_lead of the pulse that carries it. This is less than half a line.
- R7: pd_inhibit is high whenever vsync_out is high and stays high across gaps between vertical pulses. It falls on the cycle after the second line_tick that follows the end of the last vertical pulse.
- R8: line_period does not change while the inhibit window is open. It is recaptured at the first leading edge after the window closes.
- R9: With inh_disable = 1, pd_inhibit stays 0 while vsync_out is still extracted.
- R10: composite goes to 1 when vertical sync is extracted and returns to 0 when pol_neg changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Raw horizontal or composite sync, either polarity |
| line_tick | input | 1 | One-cycle pulse per line from the horizontal timebase |
| inh_disable | input | 1 | Control bit: 1 masks the phase-detector inhibit |
| sync_norm | output | 1 | Active-high normalized sync |
| sync_lead | output | 1 | One-cycle leading-edge marker |
| vsync_out | output | 1 | Extracted vertical sync |
| pd_inhibit | output | 1 | Phase-detector inhibit window |
| pol_neg | output | 1 | Detected polarity, 1 = active-low input |
| composite | output | 1 | Vertical sync found inside the sync input |
| line_period | output | CNT_W | Measured line period in sample clocks |

## Verification
The bench builds the block with its defaults: 10-bit counters, a 10-bit polarity integrator with a 512-sample half scale, and two trailing lines. Lines of 64 and 100 clocks put the width threshold at 19 and 30 samples. That lets the pulse width be swept one sample at a time across the classification edge, with the extraction latency and the high time predicted arithmetically. The short half scale makes a complete polarity reversal observable in a few dozen lines, while a 500-sample low pulse stays just under it. Serrated vertical sequences, period changes inside the window and the disable bit exercise the window's hold and exit timing.

// File: rtl/csep_pkg.sv
package csep_pkg;
    typedef enum logic [1:0] {
        INH_IDLE  = 2'd0,
        INH_VERT  = 2'd1,
        INH_TRAIL = 2'd2
    } inh_state_t;
endpackage

// File: rtl/sync_pol_norm.sv
module sync_pol_norm #(
    parameter int INTEG_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic pol_neg,
    output logic pol_flip,
    output logic norm,
    output logic lead
);
    localparam logic [INTEG_W-1:0] INT_MAX = '1;
    localparam logic [INTEG_W-1:0] INT_MID = {1'b1, {(INTEG_W-1){1'b0}}};

    logic                raw_q;
    logic [INTEG_W-1:0]  integ;
    logic                pol_q;
    logic                flip_q;
    logic                norm_q;
    logic                norm_d;
    logic                pol_nxt;

    assign pol_nxt = (integ >= INT_MID);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= 1'b0;
            integ  <= '0;
            pol_q  <= 1'b0;
            flip_q <= 1'b0;
            norm_q <= 1'b0;
            norm_d <= 1'b0;
        end else begin
            raw_q <= sync_in;
            if (raw_q) begin
                if (integ != INT_MAX) integ <= integ + 1'b1;
            end else begin
                if (integ != '0) integ <= integ - 1'b1;
            end
            pol_q  <= pol_nxt;
            flip_q <= pol_nxt ^ pol_q;
            norm_q <= raw_q ^ pol_q;
            norm_d <= norm_q;
        end
    end

    assign pol_neg  = pol_q;
    assign pol_flip = flip_q;
    assign norm     = norm_q;
    assign lead     = norm_q & ~norm_d;

    // R3
    pol_flip_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_q) |-> ($past(integ) == INT_MID || $past(integ) == INT_MID - 1'b1));
endmodule

// File: rtl/sync_width_meas.sv
module sync_width_meas #(
    parameter int CNT_W    = 10,
    parameter int FRAC_NUM = 77,
    parameter int FRAC_SH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             norm,
    input  logic             lead,
    input  logic             hold,
    output logic [CNT_W-1:0] period,
    output logic             vsync
);
    localparam int PROD_W = CNT_W + FRAC_SH;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] thr;
    logic             edge_seen;
    logic             per_valid;
    logic             vs_q;

    assign thr = CNT_W'((PROD_W'(period_q) * PROD_W'(FRAC_NUM)) >> FRAC_SH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cnt   <= '0;
            period_q  <= '0;
            wcnt      <= '0;
            edge_seen <= 1'b0;
            per_valid <= 1'b0;
            vs_q      <= 1'b0;
        end else begin
            if (lead) begin
                per_cnt   <= CNT_W'(1);
                edge_seen <= 1'b1;
            end else if (per_cnt != CNT_MAX) begin
                per_cnt <= per_cnt + 1'b1;
            end
            if (lead && edge_seen && !hold) begin
                period_q  <= per_cnt;
                per_valid <= 1'b1;
            end
            if (!norm)                wcnt <= '0;
            else if (wcnt != CNT_MAX) wcnt <= wcnt + 1'b1;
            vs_q <= norm && (vs_q || (per_valid && (wcnt >= thr)));
        end
    end

    assign period = period_q;
    assign vsync  = vs_q;

    // R5
    vs_after_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_q |-> $past(norm));
    // R8
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(period_q) |-> ($past(lead) && !$past(hold)));
    // R5
    width_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (norm && wcnt == CNT_MAX) |=> (wcnt == CNT_MAX));
endmodule

// File: rtl/inhibit_ctl.sv
module inhibit_ctl
    import csep_pkg::*;
#(
    parameter int TRAIL_LINES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic line_tick,
    input  logic inh_disable,
    input  logic pol_flip,
    output logic window,
    output logic pd_inhibit,
    output logic composite
);
    localparam int LCNT_W = $clog2(TRAIL_LINES + 1);
    localparam logic [LCNT_W-1:0] LAST_LINE = LCNT_W'(TRAIL_LINES - 1);

    inh_state_t        state, nxt;
    logic [LCNT_W-1:0] lcnt;
    logic              vs_d;
    logic              comp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= INH_IDLE;
            lcnt   <= '0;
            vs_d   <= 1'b0;
            comp_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state != INH_TRAIL) lcnt <= '0;
            else if (line_tick)     lcnt <= lcnt + 1'b1;
            vs_d <= vsync;
            if (pol_flip)            comp_q <= 1'b0;
            else if (vsync && !vs_d) comp_q <= 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            INH_IDLE:  if (vsync) nxt = INH_VERT;
            INH_VERT:  if (!vsync) nxt = INH_TRAIL;
            INH_TRAIL: begin
                if (vsync)                                nxt = INH_VERT;
                else if (line_tick && lcnt == LAST_LINE)  nxt = INH_IDLE;
            end
            default:   nxt = INH_IDLE;
        endcase
    end

    always_comb begin
        window     = (state != INH_IDLE) || vsync;
        pd_inhibit = window && !inh_disable;
        composite  = comp_q;
    end

    // R7
    vert_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (state != INH_IDLE));
    // R7
    trail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == INH_TRAIL && state == INH_IDLE) |-> $past(line_tick));
    // R7
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == INH_IDLE) |-> (state != INH_TRAIL));
endmodule

// File: rtl/composite_sync_sep.sv
module composite_sync_sep #(
    parameter int CNT_W       = 10,
    parameter int INTEG_W     = 10,
    parameter int TRAIL_LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             line_tick,
    input  logic             inh_disable,
    output logic             sync_norm,
    output logic             sync_lead,
    output logic             vsync_out,
    output logic             pd_inhibit,
    output logic             pol_neg,
    output logic             composite,
    output logic [CNT_W-1:0] line_period
);
    logic norm, lead, pol_flip, vsync, window;

    sync_pol_norm #(.INTEG_W(INTEG_W)) u_pol (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .pol_neg(pol_neg), .pol_flip(pol_flip), .norm(norm), .lead(lead)
    );

    sync_width_meas #(.CNT_W(CNT_W), .FRAC_NUM(77), .FRAC_SH(8)) u_meas (
        .clk(clk), .rst_n(rst_n), .norm(norm), .lead(lead), .hold(window),
        .period(line_period), .vsync(vsync)
    );

    inhibit_ctl #(.TRAIL_LINES(TRAIL_LINES)) u_inh (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .line_tick(line_tick),
        .inh_disable(inh_disable), .pol_flip(pol_flip), .window(window),
        .pd_inhibit(pd_inhibit), .composite(composite)
    );

    assign sync_norm = norm;
    assign sync_lead = lead;
    assign vsync_out = vsync;
endmodule

// File: tb/composite_sync_sep_tb_top.sv
module composite_sync_sep_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0;
    logic       line_tick = 1'b0;
    logic       inh_disable = 1'b0;
    logic       sync_norm, sync_lead, vsync_out, pd_inhibit, pol_neg, composite;
    logic [9:0] line_period;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  neg     = 1'b0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    composite_sync_sep dut_i (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .line_tick(line_tick),
        .inh_disable(inh_disable), .sync_norm(sync_norm), .sync_lead(sync_lead),
        .vsync_out(vsync_out), .pd_inhibit(pd_inhibit), .pol_neg(pol_neg),
        .composite(composite), .line_period(line_period)
    );

    // monitor state
    int lead_cnt, since_lead, vs_cycles, vs_rise, lat, hi_run, last_w;
    int gap_err, inh_rise, trail, drop_tr, drop_prompt, pol_chg;
    bit vs_prev, norm_prev, inh_prev, tick_prev, pol_prev;

    task automatic mon_clear();
        lead_cnt = 0; vs_cycles = 0; vs_rise = 0; lat = -1; last_w = -1;
        gap_err = 0; inh_rise = 0; drop_tr = -1; drop_prompt = 0; pol_chg = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            since_lead++;
            if (sync_lead) begin lead_cnt++; since_lead = 0; end
            if (vsync_out) vs_cycles++;
            if (vsync_out && !vs_prev) begin vs_rise++; lat = since_lead; end
            if (sync_norm) hi_run++;
            else begin
                if (norm_prev) last_w = hi_run;
                hi_run = 0;
            end
            if (vsync_out && !pd_inhibit && !inh_disable) gap_err++;
            if (pd_inhibit && !inh_prev) inh_rise++;
            if (vsync_out) trail = 0;
            else if (line_tick && pd_inhibit) trail++;
            if (!pd_inhibit && inh_prev) begin drop_tr = trail; drop_prompt = tick_prev; end
            if (pol_neg != pol_prev) pol_chg++;
            vs_prev = vsync_out; norm_prev = sync_norm; inh_prev = pd_inhibit;
            tick_prev = line_tick; pol_prev = pol_neg;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic line(input int per, input int hw, input bit tk);
        for (int i = 0; i < per; i++) begin
            @(posedge clk); #1;
            sync_in   = (i < hw) ? ~neg : neg;
            line_tick = tk && (i == 0);
        end
    endtask

    task automatic lines(input int n, input int per, input int hw);
        for (int k = 0; k < n; k++) line(per, hw, 1'b1);
    endtask

    task automatic vert_case(input int per, input int w, input int thr);
        mon_clear();
        line(per, w, 1'b1);
        lines(3, per, 6);
        chk(vs_cycles == ((w > thr) ? w - thr : 0), "R5 vsync high time", vs_cycles,
            (w > thr) ? w - thr : 0);
        if (w > thr) begin
            chk(lat == thr + 1 && lat < per / 2, "R6 extraction latency", lat, thr + 1);
            chk(drop_tr == 2 && drop_prompt == 1, "R7 trailing lines", drop_tr, 2);
            chk(gap_err == 0, "R7 inhibit covers vsync", gap_err, 0);
        end else begin
            chk(inh_rise == 0, "R5 short pulse no inhibit", inh_rise, 0);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk({sync_norm, sync_lead, vsync_out, pd_inhibit, pol_neg, composite} == 6'b0,
            "R1 reset outputs", {sync_norm, sync_lead, vsync_out, pd_inhibit, pol_neg, composite}, 0);
        chk(line_period == 0, "R1 reset period", line_period, 0);

        // positive separate sync
        lines(8, 64, 6);
        mon_clear();
        lines(4, 64, 6);
        chk(lead_cnt == 4, "R2 one lead per pulse", lead_cnt, 4);
        chk(last_w == 6, "R2 normalized width", last_w, 6);
        chk(pol_neg == 0, "R2 positive polarity", pol_neg, 0);
        chk(line_period == 64, "R4 period 64", line_period, 64);
        chk(vs_cycles == 0, "R5 no vsync on hsync", vs_cycles, 0);
        chk(composite == 0, "R10 no composite yet", composite, 0);

        // width sweep at P=64, threshold 19
        for (int w = 16; w <= 24; w++) vert_case(64, w, 19);
        chk(composite == 1, "R10 composite set", composite, 1);

        // P=100, threshold 30
        lines(5, 100, 6);
        chk(line_period == 100, "R4 period 100", line_period, 100);
        for (int w = 29; w <= 33; w++) vert_case(100, w, 30);

        // period hold inside the window
        lines(5, 64, 6);
        line(64, 30, 1'b1);
        line(80, 6, 1'b1);
        chk(pd_inhibit == 1 && line_period == 64, "R8 period held", line_period, 64);
        lines(4, 80, 6);
        chk(line_period == 80, "R8 period recaptured", line_period, 80);

        // serrated vertical interval
        lines(4, 64, 6);
        mon_clear();
        for (int k = 0; k < 4; k++) line(32, 26, (k % 2) == 0);
        lines(4, 64, 6);
        chk(vs_rise == 4, "R5 serrated pulses", vs_rise, 4);
        chk(inh_rise == 1, "R7 continuous window", inh_rise, 1);
        chk(gap_err == 0, "R7 inhibit covers vsync", gap_err, 0);
        chk(drop_tr == 2 && drop_prompt == 1, "R7 serrated trailing lines", drop_tr, 2);

        // disable bit
        inh_disable = 1'b1;
        mon_clear();
        line(64, 30, 1'b1);
        lines(3, 64, 6);
        chk(inh_rise == 0, "R9 inhibit masked", inh_rise, 0);
        chk(vs_cycles == 11, "R9 vsync still extracted", vs_cycles, 11);
        inh_disable = 1'b0;
        lines(2, 64, 6);

        // polarity reversal
        neg = 1'b1;
        lines(30, 64, 6);
        mon_clear();
        lines(4, 64, 6);
        chk(pol_neg == 1, "R2 negative polarity", pol_neg, 1);
        chk(last_w == 6, "R2 negative normalized width", last_w, 6);
        chk(lead_cnt == 4, "R2 negative leads", lead_cnt, 4);
        chk(line_period == 64, "R4 negative period", line_period, 64);
        chk(composite == 0, "R10 cleared by flip", composite, 0);

        vert_case(64, 40, 19);
        chk(composite == 1, "R10 set in negative sync", composite, 1);

        // long low excursion must not flip polarity
        lines(4, 64, 6);
        mon_clear();
        line(600, 500, 1'b1);
        lines(4, 64, 6);
        chk(pol_chg == 0 && pol_neg == 1, "R3 polarity kept", pol_chg, 0);
        chk(vs_cycles == 481, "R5 long vsync", vs_cycles, 481);
        chk(line_period == 64, "R8 period after long pulse", line_period, 64);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule